// File: doc/BRIEF.md
# Single-Cycle Processor Control Decoder

This block is the control unit of an unpipelined 32-bit, three-operand RISC datapath. It is purely combinational. It takes the 6-bit opcode of the instruction being executed and a zero flag for the value read on register port 1. From these it drives every select line of the datapath: next-PC source, second read address and B operand, A operand, ALU function, register write enable, write address, write data source and memory write enable.

Besides the usual loads, stores, branches, jump, PC-relative load and ALU operations, it decodes three extra instructions:
- a memory/register swap: the old memory word goes to Rc while Reg[Rc] is stored;
- a move-if-zero;
- a move-constant-if-zero.

The register write of the two moves depends on the live zero flag. The second-read-address select and the B-operand select share one output.

Undefined opcodes raise an illegal flag and suppress every write. An active-low reset input also suppresses all writes.

Top module: `ctl_decoder`

## Requirements
- R1: Any opcode not listed in R3 to R11 sets illegal_o=1 and drives every other output to 0.
- R2: While rst_ni=0, werf_o=0 and mem_we_o=0 for every opcode, with all other outputs decoded as usual.
- R3: a_sel_o=1 only for the PC-relative load (opcode 0x1F). That instruction also uses alufn 0xE (pass A), werf=1 and wd_sel=2.
- R4: ab_sel_o=1 (second read address = Rc, B operand = literal) for 0x18, 0x19, 0x10, 0x12 and 0x30-0x3F, and 0 for every other opcode.
- R5: Load (0x18) gives alufn 0x0 (add), werf=1, wa_sel=0, wd_sel=2 (memory data), mem_we=0, pc_sel=0.
- R6: Store (0x19) gives alufn 0x0, werf=0, mem_we=1, wd_sel=1, pc_sel=0.
- R7: Branch-if-equal (0x1C) sets pc_sel=1 (branch target) when zero_i=1, and branch-if-not-equal (0x1D) sets pc_sel=1 when zero_i=0; otherwise pc_sel=0. Both give werf=1, wd_sel=0 (PC+4), mem_we=0.
- R8: Jump (0x1B) gives pc_sel=2 (register target), werf=1, wd_sel=0.
- R9: Opcodes 0x20-0x3F give alufn = opcode[3:0], werf=1, wd_sel=1 (ALU), mem_we=0, pc_sel=0.
- R10: Swap (0x10) gives alufn 0x0, mem_we=1, werf=1, wd_sel=2, pc_sel=0.
- R11: Move-if-zero (0x11) and move-constant-if-zero (0x12) give alufn 0xF (pass B), wd_sel=1, mem_we=0, pc_sel=0, and werf_o equal to zero_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_ni | input | 1 | Active-low reset; suppresses writes |
| opcode_i | input | 6 | Instruction opcode |
| zero_i | input | 1 | Register port-1 value equals zero |
| pc_sel_o | output | 2 | Next PC: 0 PC+4, 1 branch target, 2 register target |
| ab_sel_o | output | 1 | Merged second-read-address / B-operand select |
| a_sel_o | output | 1 | A operand: 0 register, 1 PC-relative path |
| alufn_o | output | 4 | ALU function code |
| werf_o | output | 1 | Register file write enable |
| wa_sel_o | output | 1 | Write address select: 0 Rc |
| wd_sel_o | output | 2 | Write data: 0 PC+4, 1 ALU, 2 memory |
| mem_we_o | output | 1 | Memory write enable |
| illegal_o | output | 1 | Undefined opcode |

## Verification
The hardest cases to reach are the ones where the zero flag decides the result: branch direction and the conditional-move write enable. These must be seen with both flag values, and again with reset held so that the suppression of writes overrides the flag. The stimulus sweeps all 64 opcodes against every combination of zero_i and rst_ni. A behavioural reference model checks each combination, so every undefined code is covered as well.

// File: rtl/ctl_pkg.sv
package ctl_pkg;
  parameter int OP_W    = 6;
  parameter int ALUFN_W = 4;
  localparam int PCS_W  = 2;
  localparam int WDS_W  = 2;

  localparam logic [OP_W-1:0] OP_SWP  = 6'h10;
  localparam logic [OP_W-1:0] OP_MVZ  = 6'h11;
  localparam logic [OP_W-1:0] OP_MVZC = 6'h12;
  localparam logic [OP_W-1:0] OP_LD   = 6'h18;
  localparam logic [OP_W-1:0] OP_ST   = 6'h19;
  localparam logic [OP_W-1:0] OP_JMP  = 6'h1B;
  localparam logic [OP_W-1:0] OP_BEQ  = 6'h1C;
  localparam logic [OP_W-1:0] OP_BNE  = 6'h1D;
  localparam logic [OP_W-1:0] OP_LDR  = 6'h1F;

  localparam logic [ALUFN_W-1:0] FN_ADD    = 4'h0;
  localparam logic [ALUFN_W-1:0] FN_PASS_A = 4'hE;
  localparam logic [ALUFN_W-1:0] FN_PASS_B = 4'hF;

  localparam logic [PCS_W-1:0] PC_NEXT = 2'd0;
  localparam logic [PCS_W-1:0] PC_BR   = 2'd1;
  localparam logic [PCS_W-1:0] PC_JR   = 2'd2;

  localparam logic [WDS_W-1:0] WD_PC  = 2'd0;
  localparam logic [WDS_W-1:0] WD_ALU = 2'd1;
  localparam logic [WDS_W-1:0] WD_MEM = 2'd2;

  typedef enum logic [3:0] {
    C_ILL, C_LD, C_ST, C_JMP, C_BEQ, C_BNE, C_LDR,
    C_ALU, C_ALUC, C_SWP, C_MVZ, C_MVZC
  } op_class_e;

  typedef struct packed {
    logic [PCS_W-1:0]   pc_sel;
    logic               ab_sel;
    logic               a_sel;
    logic [ALUFN_W-1:0] alufn;
    logic               werf;
    logic               wa_sel;
    logic [WDS_W-1:0]   wd_sel;
    logic               mem_we;
  } ctl_t;
endpackage

// File: rtl/ctl_classify.sv
module ctl_classify
  import ctl_pkg::*;
(
  input  logic [OP_W-1:0] opcode_i,
  output op_class_e       cls_o
);
  always_comb begin
    cls_o = C_ILL;
    if (opcode_i[OP_W-1 -: 2] == 2'b10)      cls_o = C_ALU;
    else if (opcode_i[OP_W-1 -: 2] == 2'b11) cls_o = C_ALUC;
    else begin
      case (opcode_i)
        OP_LD:   cls_o = C_LD;
        OP_ST:   cls_o = C_ST;
        OP_JMP:  cls_o = C_JMP;
        OP_BEQ:  cls_o = C_BEQ;
        OP_BNE:  cls_o = C_BNE;
        OP_LDR:  cls_o = C_LDR;
        OP_SWP:  cls_o = C_SWP;
        OP_MVZ:  cls_o = C_MVZ;
        OP_MVZC: cls_o = C_MVZC;
        default: cls_o = C_ILL;
      endcase
    end
  end
endmodule

// File: rtl/ctl_fields.sv
module ctl_fields
  import ctl_pkg::*;
(
  input  op_class_e          cls_i,
  input  logic [ALUFN_W-1:0] op_fn_i,
  output ctl_t               base_o
);
  // unconditional settings; zero-dependent parts resolved in ctl_gate
  always_comb begin
    base_o = '0;
    unique case (cls_i)
      C_LD:   begin base_o.ab_sel = 1'b1; base_o.werf = 1'b1; base_o.wd_sel = WD_MEM; end
      C_ST:   begin base_o.ab_sel = 1'b1; base_o.mem_we = 1'b1; base_o.wd_sel = WD_ALU; end
      C_JMP:  begin base_o.pc_sel = PC_JR; base_o.werf = 1'b1; base_o.wd_sel = WD_PC; end
      C_BEQ, C_BNE: begin base_o.werf = 1'b1; base_o.wd_sel = WD_PC; end
      C_LDR:  begin base_o.a_sel = 1'b1; base_o.alufn = FN_PASS_A;
                    base_o.werf = 1'b1; base_o.wd_sel = WD_MEM; end
      C_ALU:  begin base_o.alufn = op_fn_i; base_o.werf = 1'b1; base_o.wd_sel = WD_ALU; end
      C_ALUC: begin base_o.alufn = op_fn_i; base_o.ab_sel = 1'b1;
                    base_o.werf = 1'b1; base_o.wd_sel = WD_ALU; end
      C_SWP:  begin base_o.ab_sel = 1'b1; base_o.alufn = FN_ADD; base_o.werf = 1'b1;
                    base_o.mem_we = 1'b1; base_o.wd_sel = WD_MEM; end
      C_MVZ:  begin base_o.alufn = FN_PASS_B; base_o.wd_sel = WD_ALU; end
      C_MVZC: begin base_o.alufn = FN_PASS_B; base_o.ab_sel = 1'b1; base_o.wd_sel = WD_ALU; end
      default: base_o = '0;
    endcase
  end
endmodule

// File: rtl/ctl_gate.sv
module ctl_gate
  import ctl_pkg::*;
(
  input  logic      rst_ni,
  input  logic      zero_i,
  input  op_class_e cls_i,
  input  ctl_t      base_i,
  output ctl_t      ctl_o
);
  always_comb begin
    ctl_o = base_i;
    if (cls_i == C_BEQ) ctl_o.pc_sel = zero_i ? PC_BR : PC_NEXT;
    if (cls_i == C_BNE) ctl_o.pc_sel = zero_i ? PC_NEXT : PC_BR;
    if (cls_i == C_MVZ || cls_i == C_MVZC) ctl_o.werf = zero_i;
    if (!rst_ni) begin
      ctl_o.werf   = 1'b0;
      ctl_o.mem_we = 1'b0;
    end
  end
endmodule

// File: rtl/ctl_decoder.sv
module ctl_decoder
  import ctl_pkg::*;
(
  input  logic               rst_ni,
  input  logic [OP_W-1:0]    opcode_i,
  input  logic               zero_i,
  output logic [PCS_W-1:0]   pc_sel_o,
  output logic               ab_sel_o,
  output logic               a_sel_o,
  output logic [ALUFN_W-1:0] alufn_o,
  output logic               werf_o,
  output logic               wa_sel_o,
  output logic [WDS_W-1:0]   wd_sel_o,
  output logic               mem_we_o,
  output logic               illegal_o
);
  op_class_e cls;
  ctl_t      base, ctl;

  ctl_classify u_cls (.opcode_i(opcode_i), .cls_o(cls));
  ctl_fields   u_fld (.cls_i(cls), .op_fn_i(opcode_i[ALUFN_W-1:0]), .base_o(base));
  ctl_gate     u_gte (.rst_ni(rst_ni), .zero_i(zero_i), .cls_i(cls), .base_i(base), .ctl_o(ctl));

  assign pc_sel_o  = ctl.pc_sel;
  assign ab_sel_o  = ctl.ab_sel;
  assign a_sel_o   = ctl.a_sel;
  assign alufn_o   = ctl.alufn;
  assign werf_o    = ctl.werf;
  assign wa_sel_o  = ctl.wa_sel;
  assign wd_sel_o  = ctl.wd_sel;
  assign mem_we_o  = ctl.mem_we;
  assign illegal_o = (cls == C_ILL);
endmodule

// File: rtl/ctl_decoder_chk.sv
module ctl_decoder_chk
  import ctl_pkg::*;
(
  input logic               rst_ni,
  input logic [OP_W-1:0]    opcode_i,
  input logic               zero_i,
  input logic [PCS_W-1:0]   pc_sel_o,
  input logic               ab_sel_o,
  input logic               a_sel_o,
  input logic [ALUFN_W-1:0] alufn_o,
  input logic               werf_o,
  input logic               wa_sel_o,
  input logic [WDS_W-1:0]   wd_sel_o,
  input logic               mem_we_o,
  input logic               illegal_o
);
  always_comb begin
    // R1
    if (illegal_o)
      ill_quiet_chk: assert (!werf_o && !mem_we_o && pc_sel_o == PC_NEXT)
        else $error("illegal opcode still writes");
    // R2
    if (!rst_ni)
      rst_quiet_chk: assert (!werf_o && !mem_we_o) else $error("write during reset");
    // R3
    if (a_sel_o)
      asel_ldr_chk: assert (opcode_i == OP_LDR) else $error("A select outside PC-relative load");
    // R6
    if (mem_we_o)
      memwr_src_chk: assert (opcode_i == OP_ST || opcode_i == OP_SWP) else $error("stray memory write");
    // R7
    if (pc_sel_o == PC_BR)
      br_sel_chk: assert (opcode_i == OP_BEQ || opcode_i == OP_BNE) else $error("stray branch select");
    // R11
    if (rst_ni && (opcode_i == OP_MVZ || opcode_i == OP_MVZC))
      cmov_we_chk: assert (werf_o == zero_i) else $error("conditional move enable wrong");
  end
endmodule

bind ctl_decoder ctl_decoder_chk chk_i (.*);

// File: tb/ctl_decoder_tb.sv
module ctl_decoder_tb_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_ni;
  logic [5:0] opcode;
  logic       zero;
  logic [1:0] pc_sel, wd_sel;
  logic       ab_sel, a_sel, werf, wa_sel, mem_we, illegal;
  logic [3:0] alufn;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  ctl_decoder dut_i (
    .rst_ni(rst_ni), .opcode_i(opcode), .zero_i(zero),
    .pc_sel_o(pc_sel), .ab_sel_o(ab_sel), .a_sel_o(a_sel), .alufn_o(alufn),
    .werf_o(werf), .wa_sel_o(wa_sel), .wd_sel_o(wd_sel), .mem_we_o(mem_we),
    .illegal_o(illegal)
  );

  function automatic logic [13:0] model(int op, bit z, bit rn);
    int pc = 0, ab = 0, a = 0, fn = 0, we = 0, wd = 0, mw = 0, ill = 0;
    if (op >= 32) begin fn = op % 16; we = 1; wd = 1; ab = (op >= 48) ? 1 : 0; end
    else case (op)
      24: begin ab = 1; we = 1; wd = 2; end
      25: begin ab = 1; mw = 1; wd = 1; end
      27: begin pc = 2; we = 1; end
      28: begin pc = z ? 1 : 0; we = 1; end
      29: begin pc = z ? 0 : 1; we = 1; end
      31: begin a = 1; fn = 14; we = 1; wd = 2; end
      16: begin ab = 1; we = 1; wd = 2; mw = 1; end
      17: begin fn = 15; we = z ? 1 : 0; wd = 1; end
      18: begin fn = 15; ab = 1; we = z ? 1 : 0; wd = 1; end
      default: ill = 1;
    endcase
    if (!rn) begin we = 0; mw = 0; end
    return {pc[1:0], ab[0], a[0], fn[3:0], we[0], 1'b0, wd[1:0], mw[0], ill[0]};
  endfunction

  function automatic string tag(int op, bit rn);
    if (!rn) return "R2";
    if (op >= 32) return (op >= 48) ? "R4" : "R9";
    case (op)
      24: return "R5";
      25: return "R6";
      27: return "R8";
      28, 29: return "R7";
      31: return "R3";
      16: return "R10";
      17, 18: return "R11";
      default: return "R1";
    endcase
  endfunction

  task automatic compare(string req);
    logic [13:0] got, exp;
    got = {pc_sel, ab_sel, a_sel, alufn, werf, wa_sel, wd_sel, mem_we, illegal};
    exp = model(int'(opcode), zero, rst_ni);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s op=%02h z=%0b rn=%0b got=%014b exp=%014b",
               req, opcode, zero, rst_ni, got, exp);
    end
  endtask

  initial begin
    rst_ni = 1'b0; opcode = 6'h18; zero = 1'b0;
    @(negedge clk);
    compare("R2");  // reset state: load with writes suppressed
    for (int r = 0; r < 2; r++)
      for (int z = 0; z < 2; z++)
        for (int op = 0; op < 64; op++) begin
          @(posedge clk);
          rst_ni = r[0]; zero = z[0]; opcode = op[5:0];
          @(negedge clk);
          compare(tag(op, r[0]));
        end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule